// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between a pixel pipeline and the pins of a parallel display interface. Each cycle of the pixel clock it takes one 24-bit RGB pixel together with horizontal sync, vertical sync and data-enable strobes. It first rearranges the three colour channels in one of four orders. It then packs the result onto 24 data lines in one of several layouts: dense 5-6-5, dense 6-6-6, padded 5-6-5 and 6-6-6 variants, or full 8-8-8. The unused lines carry zero.

Each sync and enable output has its own polarity control, launch-edge control and disable control. The output-enable pin can carry either data enable or a composite sync. One 32-bit control word sets all of this. A small register bus writes and reads the control word, and every other offset reads back a fixed identifier. The pixel clock is the block's own clock. It is passed to a pin, and its polarity can be inverted.

Top module: `rgb_disp_fmt`

## Requirements
- R1: A write at byte offset 0 stores the full 32-bit word, and a read at offset 0 returns it. A read at any other offset returns 0x00647069. A write at any other offset leaves the control word unchanged. The control word resets to 0.
- R2: Control bit 0 enables the block. While it is 0, all data lines are 0, each of hsync, vsync and output enable sits at its inactive level (equal to its invert bit), and the pixel-clock pin is low. When the bit goes from 0 to 1, the pipeline restarts from a cleared state, so the first cycle after enabling shows zero data.
- R3: Bits 15:14 reorder the channels of the input pixel {R[23:16],G[15:8],B[7:0]} into slots (first, second, third) before packing: 0 gives (R,G,B), 1 gives (B,G,R), 2 gives (G,R,B), 3 gives (B,R,G).
- R4: Bits 13:11 select a dense packing. Code 1 puts first5/second6/third5 at 15:11/10:5/4:0. Code 4 puts first6/second6/third6 at 17:12/11:6/5:0. Code 6 puts the three 8-bit slots at 23:16/15:8/7:0. All other lines are 0.
- R5: Padded packings are as follows. Code 2 puts first5 at 20:16, second6 at 13:8 and third5 at 4:0. Code 3 puts first5 at 21:17, second6 at 13:8 and third5 at 5:1. Code 5 puts first6 at 21:16, second6 at 13:8 and third6 at 5:0. All other lines are 0.
- R6: Packing codes 0 and 7 drive all 24 data lines to 0.
- R7: A reduced-width field holds the most significant bits of its channel.
- R8: Data, hsync, vsync and output enable appear one clock after the rising edge that captures them. The capture uses the control word in force before that edge.
- R9: Bits 10, 9, 8 and 7 invert the pixel clock, hsync, vsync and output enable.
- R10: Bits 6, 5 and 4 make hsync, vsync and output enable change on the falling edge that follows their rising-edge capture, half a cycle later.
- R11: Bits 3, 2 and 1 disable hsync, vsync and output enable, each of which then sits at its inactive level (its invert bit).
- R12: Bit 16 set makes the output-enable pin carry data enable. Bit 16 clear makes it carry composite sync, which is high when hsync and vsync are equal and low otherwise, before inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| pix_rgb | input | 24 | Input pixel {R,G,B} |
| pix_hsync | input | 1 | Input hsync, active high |
| pix_vsync | input | 1 | Input vsync, active high |
| pix_de | input | 1 | Input data enable, active high |
| out_data | output | 24 | Packed data lines |
| out_hsync | output | 1 | Conditioned hsync |
| out_vsync | output | 1 | Conditioned vsync |
| out_oe | output | 1 | Conditioned output enable or composite sync |
| out_pclk | output | 1 | Pixel clock pin |

## Verification
Single-channel pixels are run through every packing code. A wrong field offset, such as a padded layout shifted by one line, shows up as the channel landing on the wrong lines. Pixels with only low-order bits set show whether a design truncates from the wrong end. Falling-edge launch is checked in both halves of the cycle, so an output that moves on the rising edge is caught. The enable is toggled with a live pixel at the input: a design that does not clear its pipeline on enable shows stale data in the first cycle. Composite sync is checked over all four hsync/vsync combinations. Disable is combined with invert to confirm the inactive level, and writes to the identifier offset are checked to leave the control word alone.

// File: rtl/rgb_disp_fmt.sv
module rgb_disp_fmt #(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [23:0]       pix_rgb,
  input  logic              pix_hsync,
  input  logic              pix_vsync,
  input  logic              pix_de,
  output logic [23:0]       out_data,
  output logic              out_hsync,
  output logic              out_vsync,
  output logic              out_oe,
  output logic              out_pclk
);

  localparam int B_EN     = 0;
  localparam int B_DIS_OE = 1;
  localparam int B_DIS_VS = 2;
  localparam int B_DIS_HS = 3;
  localparam int B_NEG_OE = 4;
  localparam int B_NEG_VS = 5;
  localparam int B_NEG_HS = 6;
  localparam int B_INV_OE = 7;
  localparam int B_INV_VS = 8;
  localparam int B_INV_HS = 9;
  localparam int B_INV_CK = 10;
  localparam int B_FMT_LO = 11;
  localparam int B_ORD_LO = 14;
  localparam int B_OEMODE = 16;

  logic [31:0] ctrl_q;
  logic        en;
  logic [1:0]  order;
  logic [2:0]  fmt;
  logic        sel_ctrl;

  assign en       = ctrl_q[B_EN];
  assign order    = ctrl_q[B_ORD_LO +: 2];
  assign fmt      = ctrl_q[B_FMT_LO +: 3];
  assign sel_ctrl = (bus_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= '0;
    else if (bus_wr && sel_ctrl) ctrl_q <= bus_wdata;
  end

  assign bus_rdata = sel_ctrl ? ctrl_q : ID_VALUE;

  logic [7:0] ch_a, ch_b, ch_c;

  always_comb begin
    case (order)
      2'd1:    {ch_a, ch_b, ch_c} = {pix_rgb[7:0],   pix_rgb[15:8],  pix_rgb[23:16]};
      2'd2:    {ch_a, ch_b, ch_c} = {pix_rgb[15:8],  pix_rgb[23:16], pix_rgb[7:0]};
      2'd3:    {ch_a, ch_b, ch_c} = {pix_rgb[7:0],   pix_rgb[23:16], pix_rgb[15:8]};
      default: {ch_a, ch_b, ch_c} = pix_rgb;
    endcase
  end

  logic [23:0] packed_d;

  always_comb begin
    case (fmt)
      3'd1:    packed_d = {8'b0, ch_a[7:3], ch_b[7:2], ch_c[7:3]};
      3'd2:    packed_d = {3'b0, ch_a[7:3], 2'b0, ch_b[7:2], 3'b0, ch_c[7:3]};
      3'd3:    packed_d = {2'b0, ch_a[7:3], 3'b0, ch_b[7:2], 2'b0, ch_c[7:3], 1'b0};
      3'd4:    packed_d = {6'b0, ch_a[7:2], ch_b[7:2], ch_c[7:2]};
      3'd5:    packed_d = {2'b0, ch_a[7:2], 2'b0, ch_b[7:2], 2'b0, ch_c[7:2]};
      3'd6:    packed_d = {ch_a, ch_b, ch_c};
      default: packed_d = '0;
    endcase
  end

  logic oe_src;
  assign oe_src = ctrl_q[B_OEMODE] ? pix_de : ~(pix_hsync ^ pix_vsync);

  logic [23:0] data_q;
  logic        hs_r, vs_r, oe_r;
  logic        hs_f, vs_f, oe_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      hs_r   <= 1'b0;
      vs_r   <= 1'b0;
      oe_r   <= 1'b0;
    end else if (!en) begin
      data_q <= '0;
      hs_r   <= 1'b0;
      vs_r   <= 1'b0;
      oe_r   <= 1'b0;
    end else begin
      data_q <= packed_d;
      hs_r   <= pix_hsync;
      vs_r   <= pix_vsync;
      oe_r   <= oe_src;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_f <= 1'b0;
      vs_f <= 1'b0;
      oe_f <= 1'b0;
    end else if (!en) begin
      hs_f <= 1'b0;
      vs_f <= 1'b0;
      oe_f <= 1'b0;
    end else begin
      hs_f <= hs_r;
      vs_f <= vs_r;
      oe_f <= oe_r;
    end
  end

  logic hs_lvl, vs_lvl, oe_lvl;
  assign hs_lvl = ctrl_q[B_NEG_HS] ? hs_f : hs_r;
  assign vs_lvl = ctrl_q[B_NEG_VS] ? vs_f : vs_r;
  assign oe_lvl = ctrl_q[B_NEG_OE] ? oe_f : oe_r;

  assign out_data  = en ? data_q : '0;
  assign out_hsync = (en & ~ctrl_q[B_DIS_HS] & hs_lvl) ^ ctrl_q[B_INV_HS];
  assign out_vsync = (en & ~ctrl_q[B_DIS_VS] & vs_lvl) ^ ctrl_q[B_INV_VS];
  assign out_oe    = (en & ~ctrl_q[B_DIS_OE] & oe_lvl) ^ ctrl_q[B_INV_OE];
  assign out_pclk  = en & (clk ^ ctrl_q[B_INV_CK]);

  // R1
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=> bus_rdata == $past(bus_wdata) || bus_addr != '0);

  // R1
  id_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != '0) |=> $stable(ctrl_q));

  // R2
  off_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> data_q == '0);

  // R6
  blank_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (fmt == 3'd0 || fmt == 3'd7)) |=> data_q == '0);

  // R11
  hs_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ctrl_q[B_DIS_HS]) |-> out_hsync == ctrl_q[B_INV_HS]);

  // R8
  hs_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bus_wr) |=> hs_r == $past(pix_hsync));

endmodule

// File: tb/test_rgb_disp_fmt.sv
module test_rgb_disp_fmt;
  localparam int          AW = 4;
  localparam logic [31:0] ID = 32'h0064_7069;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [23:0]   pix_rgb = '0;
  logic          pix_hsync = 1'b0, pix_vsync = 1'b0, pix_de = 1'b0;
  logic [23:0]   out_data;
  logic          out_hsync, out_vsync, out_oe, out_pclk;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rgb_disp_fmt #(.ADDR_W(AW), .ID_VALUE(ID)) i_rgb_disp_fmt (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_rgb(pix_rgb),
    .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_de(pix_de),
    .out_data(out_data), .out_hsync(out_hsync), .out_vsync(out_vsync),
    .out_oe(out_oe), .out_pclk(out_pclk));

  // {order[2], fmt[3], pixel[24], expected[24]}
  localparam int NV = 26;
  localparam logic [52:0] VEC [0:NV-1] = '{
    {2'd0, 3'd1, 24'hFF0000, 24'h00F800}, {2'd0, 3'd1, 24'h00FF00, 24'h0007E0},
    {2'd0, 3'd1, 24'h0000FF, 24'h00001F}, {2'd0, 3'd4, 24'hFF0000, 24'h03F000},
    {2'd0, 3'd4, 24'h00FF00, 24'h000FC0}, {2'd0, 3'd4, 24'h0000FF, 24'h00003F},
    {2'd0, 3'd6, 24'h112233, 24'h112233},
    {2'd0, 3'd2, 24'hFF0000, 24'h1F0000}, {2'd0, 3'd2, 24'h00FF00, 24'h003F00},
    {2'd0, 3'd2, 24'h0000FF, 24'h00001F}, {2'd0, 3'd3, 24'hFF0000, 24'h3E0000},
    {2'd0, 3'd3, 24'h00FF00, 24'h003F00}, {2'd0, 3'd3, 24'h0000FF, 24'h00003E},
    {2'd0, 3'd5, 24'hFF0000, 24'h3F0000}, {2'd0, 3'd5, 24'h00FF00, 24'h003F00},
    {2'd0, 3'd5, 24'h0000FF, 24'h00003F},
    {2'd0, 3'd0, 24'hFFFFFF, 24'h000000}, {2'd0, 3'd7, 24'hFFFFFF, 24'h000000},
    {2'd0, 3'd1, 24'h070000, 24'h000000}, {2'd0, 3'd1, 24'h080000, 24'h000800},
    {2'd0, 3'd4, 24'h030303, 24'h000000}, {2'd0, 3'd4, 24'hFCFCFC, 24'h03FFFF},
    {2'd1, 3'd6, 24'h112233, 24'h332211}, {2'd2, 3'd6, 24'h112233, 24'h221133},
    {2'd3, 3'd6, 24'h112233, 24'h331122}, {2'd1, 3'd1, 24'hFF0000, 24'h00001F}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
    bus_addr = '0;
  endtask

  task automatic step(input logic hs, input logic vs, input logic de);
    pix_hsync = hs; pix_vsync = vs; pix_de = de;
    @(posedge clk); #2;
  endtask

  localparam logic [31:0] EN = 32'h1;
  localparam logic [31:0] DEMODE = 32'h1_0000;

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3;
    chk("R1 reset data", {8'h0, out_data}, 32'h0);
    chk("R2 reset hsync", {31'h0, out_hsync}, 32'h0);
    rd_chk("R1 reset ctrl", 0, 32'h0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(posedge clk); #2;

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = (i < 7) ? "R4" : (i < 16) ? "R5" : (i < 18) ? "R6" : (i < 22) ? "R7" : "R3";
      wr(0, EN | DEMODE | (32'(VEC[i][52:51]) << 14) | (32'(VEC[i][50:48]) << 11));
      pix_rgb = VEC[i][47:24];
      @(posedge clk); #2;
      chk(tg, {8'h0, out_data}, {8'h0, VEC[i][23:0]});
    end

    // R8 latency: a new pixel is not visible before the next rising edge
    wr(0, EN | DEMODE | (32'd6 << 11));
    pix_rgb = 24'hABCDEF;
    @(posedge clk); #2;
    chk("R8 data", {8'h0, out_data}, 32'hABCDEF);
    pix_rgb = 24'h123456; #4;
    chk("R8 hold", {8'h0, out_data}, 32'hABCDEF);

    step(1, 0, 1);
    chk("R8 hsync", {31'h0, out_hsync}, 1);
    chk("R8 vsync", {31'h0, out_vsync}, 0);
    chk("R12 de mode", {31'h0, out_oe}, 1);

    // R9 invert
    wr(0, EN | DEMODE | (32'hF << 7));
    step(1, 0, 1);
    chk("R9 hsync", {31'h0, out_hsync}, 0);
    chk("R9 vsync", {31'h0, out_vsync}, 1);
    chk("R9 oe", {31'h0, out_oe}, 0);
    chk("R9 pclk high phase", {31'h0, out_pclk}, 0);
    #4;
    chk("R9 pclk low phase", {31'h0, out_pclk}, 1);

    // R10 falling-edge launch
    wr(0, EN | DEMODE | (32'h7 << 4));
    step(0, 1, 0);
    chk("R10 hsync before fall", {31'h0, out_hsync}, 1);
    chk("R10 vsync before fall", {31'h0, out_vsync}, 0);
    chk("R10 oe before fall", {31'h0, out_oe}, 1);
    #4;
    chk("R10 hsync after fall", {31'h0, out_hsync}, 0);
    chk("R10 vsync after fall", {31'h0, out_vsync}, 1);
    chk("R10 oe after fall", {31'h0, out_oe}, 0);

    // R11 disable, plain then with invert
    wr(0, EN | DEMODE | (32'h7 << 1));
    step(1, 1, 1);
    chk("R11 hsync", {31'h0, out_hsync}, 0);
    chk("R11 vsync", {31'h0, out_vsync}, 0);
    chk("R11 oe", {31'h0, out_oe}, 0);
    wr(0, EN | DEMODE | (32'h7 << 1) | (32'h7 << 7));
    step(1, 1, 1);
    chk("R11 hsync inv", {31'h0, out_hsync}, 1);
    chk("R11 vsync inv", {31'h0, out_vsync}, 1);
    chk("R11 oe inv", {31'h0, out_oe}, 1);

    // R12 composite sync
    wr(0, EN);
    step(1, 0, 1); chk("R12 csync 10", {31'h0, out_oe}, 0);
    step(1, 1, 0); chk("R12 csync 11", {31'h0, out_oe}, 1);
    step(0, 0, 0); chk("R12 csync 00", {31'h0, out_oe}, 1);
    step(0, 1, 1); chk("R12 csync 01", {31'h0, out_oe}, 0);

    // R2 disabled outputs and clean restart
    pix_rgb = 24'hFFFFFF;
    wr(0, (32'd6 << 11) | (32'h1 << 9));
    step(1, 1, 1);
    chk("R2 data off", {8'h0, out_data}, 0);
    chk("R2 hsync inactive", {31'h0, out_hsync}, 1);
    chk("R2 vsync inactive", {31'h0, out_vsync}, 0);
    #4;
    chk("R2 pclk low", {31'h0, out_pclk}, 0);
    @(posedge clk); #2;
    wr(0, EN | (32'd6 << 11));
    chk("R2 first cycle cleared", {8'h0, out_data}, 0);
    @(posedge clk); #2;
    chk("R2 running", {8'h0, out_data}, 32'hFFFFFF);

    // R1 register access
    wr(0, 32'hFFFF_FFFF);
    rd_chk("R1 readback", 0, 32'hFFFF_FFFF);
    wr(4, 32'h0);
    rd_chk("R1 id write ignored", 0, 32'hFFFF_FFFF);
    rd_chk("R1 id at 4", 4, ID);
    rd_chk("R1 id at 8", 8, ID);
    rd_chk("R1 id at top", 4'hC, ID);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule